// File: doc/BRIEF.md
# Lossy Fixed-Depth Word Stack

This block is a hardware last-in first-out store of 16-bit words for a small processor core. The core drives a push strobe with a data word, or a pop strobe, and always sees the current top word on the read port. The block never reports full or empty. A push onto a full stack silently drops the oldest word, and every slot vacated by a pop is refilled with zero, so popping an empty stack yields 0x0000.

The slots form a shift register. A push moves every word one place down and writes the new word on top. A pop moves every word one place up and feeds zero in at the bottom. A push and a pop in the same cycle act as a pop followed by a push, which replaces the top word and leaves the rest untouched. The block also presents its fixed depth, saturated to 16 bits, so the core can load its stack-size register at reset.

Top module: `lossy_stack`

## Requirements
- R1: While reset is active, and at the first cycle after its synchronous release, every slot holds zero, so the read port shows 0x0000.
- R2: The depth output equals the DEPTH parameter, limited to 0xFFFF (16 with the default parameters).
- R3: A push-only cycle makes the pushed word appear on the read port from the next cycle on.
- R4: Pops return words in the reverse order of their pushes. During a pop cycle the read port shows the word being removed.
- R5: Every slot vacated by a pop becomes zero: after N pushes onto an empty stack, pop number N+1 returns 0x0000.
- R6: When DEPTH words are held, a further push discards the oldest word. After DEPTH+1 pushes, the next DEPTH pops return the last DEPTH words newest first, and the pop after them returns 0x0000.
- R7: A cycle with both push and pop replaces the top word with the input word and leaves every other slot unchanged. On an empty stack this leaves exactly one word.
- R8: A cycle with neither push nor pop leaves all slots unchanged.
- R9: A pop on an empty stack changes nothing, returns 0x0000 and raises no error. A later push behaves normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| push_i | input | 1 | Push strobe for the current cycle |
| pop_i | input | 1 | Pop strobe for the current cycle |
| wr_data_i | input | 16 | Word to push |
| top_data_o | output | 16 | Current top word; the word returned by a pop |
| depth_o | output | 16 | Fixed stack depth, saturated at 0xFFFF |

## Verification
The bench drives overflow by pushing one word more than the depth and then drains past empty. A design that dropped the newest word instead of the oldest, or that wrapped an index, would return the wrong sequence or a stale non-zero word where 0x0000 is due. Simultaneous push and pop is exercised on full, partly filled and empty stacks. A design that shifted in that case would lose or duplicate a lower word, and that shows up later as the stack drains. Pops on an empty stack, idle stretches and a long pseudo-random command mix catch designs that disturb contents when idle, or that leave old data behind in vacated slots.

// File: rtl/lossy_stack_pkg.sv
package lossy_stack_pkg;

  typedef enum logic [1:0] {
    STK_IDLE = 2'd0,
    STK_PUSH = 2'd1,
    STK_POP  = 2'd2,
    STK_SWAP = 2'd3
  } stk_op_e;

  localparam int unsigned DEPTH_SAT_MAX = 65535;

  function automatic int unsigned sat_depth(input int unsigned d);
    return (d > DEPTH_SAT_MAX) ? DEPTH_SAT_MAX : d;
  endfunction

endpackage

// File: rtl/lstk_rst_sync.sv
module lstk_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/lstk_op_decode.sv
module lstk_op_decode
  import lossy_stack_pkg::*;
(
  input  logic    push_i,
  input  logic    pop_i,
  output stk_op_e op_o
);
  always_comb begin
    unique case ({push_i, pop_i})
      2'b10:   op_o = STK_PUSH;
      2'b01:   op_o = STK_POP;
      2'b11:   op_o = STK_SWAP;
      default: op_o = STK_IDLE;
    endcase
  end
endmodule

// File: rtl/lstk_slot_array.sv
module lstk_slot_array
  import lossy_stack_pkg::*;
#(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  stk_op_e           op_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic [WORD_W-1:0] top_o
);
  localparam int unsigned LAST = DEPTH - 1;

  logic [WORD_W-1:0] slot_q [DEPTH];
  logic [WORD_W-1:0] slot_d [DEPTH];
  logic [DEPTH-1:0]  slot_en;

  // Tracks that one full cycle has passed out of reset; used by checks only.
  logic past_ok_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok_q <= 1'b0;
    else        past_ok_q <= 1'b1;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [WORD_W-1:0] from_above;
    logic [WORD_W-1:0] from_below;

    if (i == 0) begin : g_top
      assign from_above = wr_data_i;
    end else begin : g_mid_a
      assign from_above = slot_q[i-1];
    end

    if (i == LAST) begin : g_bot
      assign from_below = '0;
    end else begin : g_mid_b
      assign from_below = slot_q[i+1];
    end

    always_comb begin
      slot_en[i] = 1'b0;
      slot_d[i]  = slot_q[i];
      unique case (op_i)
        STK_PUSH: begin
          slot_en[i] = 1'b1;
          slot_d[i]  = from_above;
        end
        STK_POP: begin
          slot_en[i] = 1'b1;
          slot_d[i]  = from_below;
        end
        STK_SWAP: begin
          if (i == 0) begin
            slot_en[i] = 1'b1;
            slot_d[i]  = wr_data_i;
          end
        end
        default: ;
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          slot_q[i] <= '0;
      else if (slot_en[i]) slot_q[i] <= slot_d[i];
    end

    // R8: an idle cycle leaves this slot untouched
    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok_q && $past(op_i) == STK_IDLE) |-> $stable(slot_q[i]));

    if (i > 0) begin : g_chk_push
      // R6: a push moves each word one place toward the bottom
      assert_push_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok_q && $past(op_i) == STK_PUSH) |-> slot_q[i] == $past(slot_q[i-1]));
      // R7: a combined push and pop leaves the lower slots alone
      assert_swap_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok_q && $past(op_i) == STK_SWAP) |-> $stable(slot_q[i]));
    end

    if (i < LAST) begin : g_chk_pop
      // R4: a pop moves each word one place toward the top
      assert_pop_shift_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok_q && $past(op_i) == STK_POP) |-> slot_q[i] == $past(slot_q[i+1]));
    end
  end

  // R3: a pushed word lands on top
  assert_push_top_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok_q && $past(op_i) == STK_PUSH) |-> slot_q[0] == $past(wr_data_i));

  // R7: a combined push and pop writes the input word on top
  assert_swap_top_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok_q && $past(op_i) == STK_SWAP) |-> slot_q[0] == $past(wr_data_i));

  // R5: a pop fills the bottom slot with zero
  assert_pop_zero_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok_q && $past(op_i) == STK_POP) |-> slot_q[LAST] == '0);

  assign top_o = slot_q[0];
endmodule

// File: rtl/lossy_stack.sv
module lossy_stack
  import lossy_stack_pkg::*;
#(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned WORD_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        push_i,
  input  logic        pop_i,
  input  logic [15:0] wr_data_i,
  output logic [15:0] top_data_o,
  output logic [15:0] depth_o
);
  localparam int unsigned DEPTH_REPORT = sat_depth(DEPTH);

  logic    rst_sync_n;
  stk_op_e op;

  lstk_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  lstk_op_decode u_decode (
    .push_i (push_i),
    .pop_i  (pop_i),
    .op_o   (op)
  );

  lstk_slot_array #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_slots (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .op_i      (op),
    .wr_data_i (wr_data_i[WORD_W-1:0]),
    .top_o     (top_data_o[WORD_W-1:0])
  );

  if (WORD_W < 16) begin : g_pad
    assign top_data_o[15:WORD_W] = '0;
  end

  assign depth_o = 16'(DEPTH_REPORT);

  // R1: the read port shows zero while the internal reset is held
  assert_reset_zero_R1: assert property (@(posedge clk)
    !rst_sync_n |-> top_data_o == 16'h0000);
endmodule

// File: tb/lossy_stack_bench.sv
module lossy_stack_bench;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        push_i, pop_i;
  logic [15:0] wr_data_i;
  logic [15:0] top_data_o, depth_o;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  logic [15:0] model_q[$];
  logic [15:0] lfsr;

  always #2.5 clk = ~clk;

  lossy_stack #(.DEPTH(DEPTH), .WORD_W(16)) u_lossy_stack (
    .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i),
    .wr_data_i(wr_data_i), .top_data_o(top_data_o), .depth_o(depth_o)
  );

  task automatic check_val(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] model_top();
    return (model_q.size() > 0) ? model_q[0] : 16'h0000;
  endfunction

  task automatic model_update(input logic ps, input logic pp, input logic [15:0] d);
    if (ps && pp) begin
      if (model_q.size() > 0) model_q[0] = d;
      else model_q.push_front(d);
    end else if (ps) begin
      model_q.push_front(d);
      if (model_q.size() > DEPTH) void'(model_q.pop_back());
    end else if (pp) begin
      if (model_q.size() > 0) void'(model_q.pop_front());
    end
  endtask

  // Drive one command, let it take effect, compare the top word away from the edge.
  task automatic step(input string tag, input logic ps, input logic pp, input logic [15:0] d);
    push_i = ps; pop_i = pp; wr_data_i = d;
    if (pp) check_val({tag, " popped"}, top_data_o, model_top());
    @(posedge clk);
    model_update(ps, pp, d);
    @(negedge clk);
    push_i = 1'b0; pop_i = 1'b0;
    check_val(tag, top_data_o, model_top());
  endtask

  initial begin
    rst_n = 1'b0; push_i = 1'b0; pop_i = 1'b0; wr_data_i = 16'h0000;
    repeat (4) @(negedge clk);
    check_val("R1 top during reset", top_data_o, 16'h0000);
    check_val("R2 depth", depth_o, 16'(DEPTH));
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_val("R1 top after release", top_data_o, 16'h0000);

    // R9: pops on an empty stack
    step("R9 empty pop", 1'b0, 1'b1, 16'hDEAD);
    step("R9 empty pop", 1'b0, 1'b1, 16'hBEEF);
    step("R9 push after empty pops", 1'b1, 1'b0, 16'h1234);
    step("R5 drain", 1'b0, 1'b1, 16'h0);

    // R3 and R4: fill a few words and pop back
    for (int i = 0; i < 5; i++) step("R3 push", 1'b1, 1'b0, 16'hA000 + 16'(i));
    for (int i = 0; i < 3; i++) step("R4 pop order", 1'b0, 1'b1, 16'h0);

    // R7: combined push and pop on a partly filled stack
    step("R7 swap", 1'b1, 1'b1, 16'h5A5A);
    step("R7 swap again", 1'b1, 1'b1, 16'hC3C3);

    // R8: idle cycles hold contents
    for (int i = 0; i < 4; i++) step("R8 idle", 1'b0, 1'b0, 16'hFFFF);

    // R5: drain past empty
    for (int i = 0; i < 4; i++) step("R5 pop past empty", 1'b0, 1'b1, 16'h0);

    // R7: combined push and pop on an empty stack leaves one word
    step("R7 swap empty", 1'b1, 1'b1, 16'h7777);
    step("R7 single word pop", 1'b0, 1'b1, 16'h0);
    step("R7 now empty", 1'b0, 1'b1, 16'h0);

    // R6: overflow by one, then drain past empty
    for (int i = 0; i <= DEPTH; i++) step("R6 overflow push", 1'b1, 1'b0, 16'h3100 + 16'(i));
    step("R7 swap full", 1'b1, 1'b1, 16'hE0E0);
    for (int i = 0; i <= DEPTH + 1; i++) step("R6 drain", 1'b0, 1'b1, 16'h0);

    // Pseudo-random mix of all commands
    lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step("R4 R6 R7 R8 mix", lfsr[0] | lfsr[3], lfsr[1] & ~lfsr[5], lfsr ^ 16'(i));
    end
    for (int i = 0; i <= DEPTH; i++) step("R5 final drain", 1'b0, 1'b1, 16'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule